// File: doc/BRIEF.md
# Network Interrupt Command Issuer

This block sits between a host register port and a packet network. The host fills in a 32-bit payload register and a target-node register. It then writes an 8-bit command register. The low three bits of the command pick the interrupt kind, and bit 3 asks for a broadcast. A command write captures everything it needs into a one-entry hold stage and becomes a packet on a valid/ready output. That packet carries the local node ID, the target, the broadcast flag, the kind and the payload.

Ordinary data writes bound for the network pass through the block in a small in-order write queue, which has a valid/ready stream on each side. A command packet is offered only after every data write accepted up to and including the cycle of the command write has left the queue. Data writes accepted later do not hold it back.

Back-pressure works the same way on all three streams. A transfer happens on a rising edge where valid and ready are both high. A producer holds its valid and its fields steady until that edge.

- A full write queue drops `dw_in_ready`.
- A packet that waits on `pkt_ready` keeps `cmd_busy` high.
- A command write made while `cmd_busy` is high is discarded. The host must poll `cmd_busy` first.

The three reserved kinds send nothing. They only raise a sticky local flag.

Top module: `nic_issuer`

## Requirements
- R1: While reset is held and after it is released, `pkt_valid`, `dw_out_valid`, `cmd_busy` and `own_data_flag` are 0, `dw_in_ready` is 1, and every register reads 0.
- R2: Register reads are combinational on `host_rdata` and change no state. Address 0 returns the 32-bit payload. Address 1 returns the 8-bit target zero-extended. Address 2 returns the 8-bit command zero-extended. Address 3 returns 0 and ignores writes.
- R3: An accepted command whose low three bits are 000, 001, 010, 011 or 111 yields exactly one packet. In that packet `pkt_type` equals those three bits, `pkt_sender` equals `my_node_id`, and `pkt_data` equals the payload register at the time of the command write. Code 000 is the reset-node request, and 111 is interrupt kind 4.
- R4: If command bit 3 is 1, then `pkt_bcast` is 1 and `pkt_target` is 8'hFF whatever the target register holds. If bit 3 is 0, then `pkt_bcast` is 0 and `pkt_target` equals the target register.
- R5: An accepted command whose low three bits are 100, 101 or 110 sends no packet and leaves `cmd_busy` low. It sets `own_data_flag`, which then stays 1 until reset.
- R6: `pkt_valid` stays low until every data write accepted on or before the command-write cycle has been handed out on `dw_out`.
- R7: While `pkt_valid` is high and `pkt_ready` is low, all packet fields hold steady. Later writes to the payload or target register do not alter a pending packet.
- R8: `cmd_busy` is high from the edge after a non-reserved command is accepted until the packet transfers. A command write while `cmd_busy` is high changes neither the command register nor the packet stream.
- R9: The write queue returns data writes in arrival order and holds `WQ_DEPTH` entries. `dw_in_ready` is low exactly when it is full, and `dw_out_valid` is high exactly when it is not empty.
- R10: Data writes accepted after the command-write cycle do not delay the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| my_node_id | input | 8 | Local node ID placed in every packet |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 2 | Register select: 0 payload, 1 target, 2 command |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for `host_addr` |
| cmd_busy | output | 1 | Hold stage occupied; command writes are discarded |
| own_data_flag | output | 1 | Sticky flag set by a reserved command |
| dw_in_valid | input | 1 | Data write offered |
| dw_in_ready | output | 1 | Write queue can accept |
| dw_in_data | input | DW_W | Data write contents (opaque) |
| dw_out_valid | output | 1 | Queued data write available |
| dw_out_ready | input | 1 | Network takes the data write |
| dw_out_data | output | DW_W | Oldest queued data write |
| pkt_valid | output | 1 | Interrupt packet available |
| pkt_ready | input | 1 | Network takes the packet |
| pkt_sender | output | 8 | Sender node ID |
| pkt_target | output | 8 | Target node ID, 8'hFF on broadcast |
| pkt_bcast | output | 1 | Broadcast flag |
| pkt_type | output | 3 | Interrupt kind code |
| pkt_data | output | 32 | Payload word |

## Verification
The risky coincidence is a command write landing in the same cycle as a write-queue push and a write-queue pop. The number of data writes the packet must wait behind then depends on counting the push in and the pop out. Directed steps stage exactly this overlap on a partly filled queue, and the random phase produces it often. A bench model predicts the wait as the queue size plus the push minus the pop. It flags any cycle where `pkt_valid` rises before that many pops have been seen, or is still low after them.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int NODE_W = 8;
  localparam int DATA_W = 32;
  localparam int KIND_W = 3;
  localparam int CMD_W  = 8;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_TGT  = 2'd1;
  localparam logic [1:0] ADDR_CMD  = 2'd2;

  localparam logic [NODE_W-1:0] BCAST_NODE = '1;

  typedef struct packed {
    logic [NODE_W-1:0] sender;
    logic [NODE_W-1:0] target;
    logic              bcast;
    logic [KIND_W-1:0] kind;
    logic [DATA_W-1:0] data;
  } nic_pkt_t;

  // kinds 100, 101, 110 carry no packet
  function automatic logic kind_reserved(input logic [KIND_W-1:0] k);
    return k[2] && (k[1:0] != 2'b11);
  endfunction
endpackage

// File: rtl/nic_regs.sv
module nic_regs
  import nic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data_q,
  output logic [NODE_W-1:0] tgt_q,
  output logic [CMD_W-1:0]  cmd_q,
  output logic              cmd_fire
);
  assign cmd_fire = wr && (addr == ADDR_CMD) && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      tgt_q  <= '0;
      cmd_q  <= '0;
    end else begin
      if (wr && addr == ADDR_DATA) data_q <= wdata;
      if (wr && addr == ADDR_TGT)  tgt_q  <= wdata[NODE_W-1:0];
      if (cmd_fire)                cmd_q  <= wdata[CMD_W-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_DATA: rdata = data_q;
      ADDR_TGT:  rdata = DATA_W'(tgt_q);
      ADDR_CMD:  rdata = DATA_W'(cmd_q);
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/nic_wq.sv
module nic_wq #(
  parameter int W     = 64,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count,
  output logic          push,
  output logic          pop
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;
  assign out_data  = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end
endmodule

// File: rtl/nic_launch.sv
module nic_launch
  import nic_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_fire,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic [DATA_W-1:0] data,
  input  logic [NODE_W-1:0] tgt,
  input  logic [NODE_W-1:0] node_id,
  input  logic [CW-1:0]     wq_count,
  input  logic              wq_push,
  input  logic              wq_pop,
  input  logic              pkt_ready,
  output nic_pkt_t          pkt,
  output logic              pkt_valid,
  output logic              busy,
  output logic              own_flag
);
  logic          full;
  logic [CW-1:0] ahead;
  logic          rsv;
  logic          bc;

  assign rsv       = kind_reserved(cmd_code[KIND_W-1:0]);
  assign bc        = cmd_code[3];
  assign busy      = full;
  assign pkt_valid = full && (ahead == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      ahead    <= '0;
      own_flag <= 1'b0;
      pkt      <= '0;
    end else if (cmd_fire) begin
      if (rsv) begin
        own_flag <= 1'b1;
      end else begin
        full       <= 1'b1;
        ahead      <= wq_count + CW'(wq_push) - CW'(wq_pop);
        pkt.sender <= node_id;
        pkt.target <= bc ? BCAST_NODE : tgt;
        pkt.bcast  <= bc;
        pkt.kind   <= cmd_code[KIND_W-1:0];
        pkt.data   <= data;
      end
    end else if (full) begin
      if (ahead != '0 && wq_pop) ahead <= ahead - 1'b1;
      if (pkt_valid && pkt_ready) full <= 1'b0;
    end
  end
endmodule

// File: rtl/nic_issuer.sv
module nic_issuer
  import nic_pkg::*;
#(
  parameter int DW_W     = 64,
  parameter int WQ_DEPTH = 4,
  localparam int CW      = $clog2(WQ_DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [7:0]      my_node_id,
  input  logic            host_wr,
  input  logic [1:0]      host_addr,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  output logic            cmd_busy,
  output logic            own_data_flag,
  input  logic            dw_in_valid,
  output logic            dw_in_ready,
  input  logic [DW_W-1:0] dw_in_data,
  output logic            dw_out_valid,
  input  logic            dw_out_ready,
  output logic [DW_W-1:0] dw_out_data,
  output logic            pkt_valid,
  input  logic            pkt_ready,
  output logic [7:0]      pkt_sender,
  output logic [7:0]      pkt_target,
  output logic            pkt_bcast,
  output logic [2:0]      pkt_type,
  output logic [31:0]     pkt_data
);
  logic [DATA_W-1:0] data_q;
  logic [NODE_W-1:0] tgt_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              cmd_fire;
  logic [CW-1:0]     wq_count;
  logic              wq_push, wq_pop;
  nic_pkt_t          pkt;

  nic_regs u_regs (
    .clk, .rst_n,
    .wr(host_wr), .addr(host_addr), .wdata(host_wdata), .busy(cmd_busy),
    .rdata(host_rdata), .data_q, .tgt_q, .cmd_q, .cmd_fire
  );

  nic_wq #(.W(DW_W), .DEPTH(WQ_DEPTH)) u_wq (
    .clk, .rst_n,
    .in_valid(dw_in_valid), .in_ready(dw_in_ready), .in_data(dw_in_data),
    .out_valid(dw_out_valid), .out_ready(dw_out_ready), .out_data(dw_out_data),
    .count(wq_count), .push(wq_push), .pop(wq_pop)
  );

  nic_launch #(.CW(CW)) u_launch (
    .clk, .rst_n,
    .cmd_fire, .cmd_code(host_wdata[CMD_W-1:0]),
    .data(data_q), .tgt(tgt_q), .node_id(my_node_id),
    .wq_count, .wq_push, .wq_pop,
    .pkt_ready, .pkt, .pkt_valid,
    .busy(cmd_busy), .own_flag(own_data_flag)
  );

  assign pkt_sender = pkt.sender;
  assign pkt_target = pkt.target;
  assign pkt_bcast  = pkt.bcast;
  assign pkt_type   = pkt.kind;
  assign pkt_data   = pkt.data;
endmodule

// File: rtl/nic_issuer_chk.sv
module nic_issuer_chk #(
  parameter int WQ_DEPTH = 4,
  localparam int CW      = $clog2(WQ_DEPTH + 1)
) (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  my_node_id,
  input logic        host_wr,
  input logic [1:0]  host_addr,
  input logic [2:0]  host_kind,
  input logic        cmd_busy,
  input logic        own_data_flag,
  input logic        dw_in_valid,
  input logic        dw_in_ready,
  input logic        dw_out_valid,
  input logic        dw_out_ready,
  input logic        pkt_valid,
  input logic        pkt_ready,
  input logic [7:0]  pkt_sender,
  input logic [7:0]  pkt_target,
  input logic        pkt_bcast,
  input logic [2:0]  pkt_type,
  input logic [31:0] pkt_data
);
  logic          push, pop, acc, acc_rsv;
  logic [CW-1:0] occ, wait_n;

  assign push    = dw_in_valid && dw_in_ready;
  assign pop     = dw_out_valid && dw_out_ready;
  assign acc     = host_wr && host_addr == 2'd2 && !cmd_busy;
  assign acc_rsv = acc && host_kind[2] && host_kind[1:0] != 2'b11;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= '0;
      wait_n <= '0;
    end else begin
      occ <= occ + CW'(push) - CW'(pop);
      if (acc && !acc_rsv)           wait_n <= occ + CW'(push) - CW'(pop);
      else if (pop && wait_n != '0)  wait_n <= wait_n - 1'b1;
    end
  end

  // R7
  pkt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid &&
      $stable({pkt_sender, pkt_target, pkt_bcast, pkt_type, pkt_data}));
  // R6
  pkt_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> wait_n == '0);
  // R8
  busy_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> cmd_busy);
  // R9
  wq_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dw_in_ready == (occ != CW'(WQ_DEPTH)));
  // R5
  rsv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rsv |=> own_data_flag && !cmd_busy);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    own_data_flag |=> own_data_flag);
  // R4
  bcast_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_bcast |-> pkt_target == 8'hFF);
  // R3
  pkt_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !(pkt_type[2] && pkt_type[1:0] != 2'b11) && pkt_sender == my_node_id);
endmodule

bind nic_issuer nic_issuer_chk #(.WQ_DEPTH(WQ_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .my_node_id(my_node_id),
  .host_wr(host_wr), .host_addr(host_addr), .host_kind(host_wdata[2:0]),
  .cmd_busy(cmd_busy), .own_data_flag(own_data_flag),
  .dw_in_valid(dw_in_valid), .dw_in_ready(dw_in_ready),
  .dw_out_valid(dw_out_valid), .dw_out_ready(dw_out_ready),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
  .pkt_sender(pkt_sender), .pkt_target(pkt_target), .pkt_bcast(pkt_bcast),
  .pkt_type(pkt_type), .pkt_data(pkt_data)
);

// File: tb/tb_nic_issuer.sv
`timescale 1ns/1ps
module tb_nic_issuer;
  localparam int DW    = 64;
  localparam int DEPTH = 4;
  localparam logic [7:0] NODE = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] my_node_id = NODE;
  logic host_wr = 1'b0;
  logic [1:0] host_addr = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic cmd_busy, own_data_flag;
  logic dw_in_valid = 1'b0;
  logic dw_in_ready;
  logic [DW-1:0] dw_in_data = '0;
  logic dw_out_valid;
  logic dw_out_ready = 1'b0;
  logic [DW-1:0] dw_out_data;
  logic pkt_valid;
  logic pkt_ready = 1'b1;
  logic [7:0] pkt_sender, pkt_target;
  logic pkt_bcast;
  logic [2:0] pkt_type;
  logic [31:0] pkt_data;

  always #5 clk = ~clk;

  nic_issuer #(.DW_W(DW), .WQ_DEPTH(DEPTH)) dut (.*);

  int checks = 0, errors = 0, pkt_cnt = 0;
  bit mon_on = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit is_rsv(input logic [2:0] k);
    return k[2] && k[1:0] != 2'b11;
  endfunction

  function automatic logic [51:0] mk_pkt(input logic [7:0] code, input logic [7:0] tgt, input logic [31:0] d);
    return {NODE, code[3] ? 8'hFF : tgt, code[3], code[2:0], d};
  endfunction

  // bench model
  logic [DW-1:0] dq[$];
  logic [31:0] data_m = '0;
  logic [7:0]  tgt_m = '0, cmd_m = '0;
  logic [51:0] exp_pkt = '0;
  bit exp_busy = 1'b0, exp_flag = 1'b0;
  int ahead_m = 0;

  always @(negedge clk) begin
    #3;
    if (rst_n && mon_on) begin
      automatic bit push = dw_in_valid && dw_in_ready;
      automatic bit pop = dw_out_valid && dw_out_ready;
      automatic bit acc = host_wr && host_addr == 2'd2 && !exp_busy;
      chk(dw_in_ready == (dq.size() < DEPTH), "R9 in_ready", 64'(dw_in_ready), 64'(dq.size() < DEPTH));
      chk(dw_out_valid == (dq.size() != 0), "R9 out_valid", 64'(dw_out_valid), 64'(dq.size() != 0));
      if (pop && dq.size() != 0) chk(dw_out_data == dq[0], "R9 order", dw_out_data, dq[0]);
      chk(cmd_busy == exp_busy, "R8 busy", 64'(cmd_busy), 64'(exp_busy));
      chk(own_data_flag == exp_flag, "R5 flag", 64'(own_data_flag), 64'(exp_flag));
      chk(pkt_valid == (exp_busy && ahead_m == 0), "R6 R10 pkt_valid", 64'(pkt_valid), 64'(exp_busy && ahead_m == 0));
      if (pkt_valid)
        chk({pkt_sender, pkt_target, pkt_bcast, pkt_type, pkt_data} == exp_pkt, "R3 R4 R7 fields",
            64'({pkt_sender, pkt_target, pkt_bcast, pkt_type, pkt_data}), 64'(exp_pkt));
      if (pkt_valid && pkt_ready) begin exp_busy = 1'b0; pkt_cnt++; end
      if (pop && exp_busy && ahead_m > 0) ahead_m--;
      if (acc) begin
        cmd_m = host_wdata[7:0];
        if (is_rsv(host_wdata[2:0])) exp_flag = 1'b1;
        else begin
          exp_busy = 1'b1;
          exp_pkt = mk_pkt(host_wdata[7:0], tgt_m, data_m);
          ahead_m = dq.size() + int'(push) - int'(pop);
        end
      end
      if (host_wr && host_addr == 2'd0) data_m = host_wdata;
      if (host_wr && host_addr == 2'd1) tgt_m = host_wdata[7:0];
      if (pop && dq.size() != 0) void'(dq.pop_front());
      if (push) dq.push_back(dw_in_data);
    end
  end

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); host_wr = 1'b0; host_addr = a; #1 d = host_rdata;
  endtask

  task automatic dpush(input logic [DW-1:0] d);
    @(negedge clk); dw_in_valid = 1'b1; dw_in_data = d;
    @(negedge clk); dw_in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && (cmd_busy || dw_out_valid); i++) @(negedge clk);
  endtask

  task automatic rnd_cycle();
    @(negedge clk);
    host_wr      = ($urandom % 6 == 0);
    host_addr    = 2'($urandom % 3);
    host_wdata   = $urandom;
    dw_in_valid  = $urandom % 2;
    dw_in_data   = {$urandom, $urandom};
    dw_out_ready = ($urandom % 4 != 0);
    pkt_ready    = ($urandom % 3 != 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int base;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1 in reset
    chk(!pkt_valid && !dw_out_valid && !cmd_busy && !own_data_flag && dw_in_ready, "R1 outputs",
        {pkt_valid, dw_out_valid, cmd_busy, own_data_flag, dw_in_ready}, 5'b00001);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      hread(2'(a), rd);
      chk(rd == 0, "R1 reg", rd, 0);
    end
    mon_on = 1'b1;

    // R2 readback
    hwrite(2'd0, 32'hCAFE_1234);
    hwrite(2'd1, 32'hFFFF_FF37);
    hwrite(2'd3, 32'h1111_1111);
    hread(2'd0, rd); chk(rd == 32'hCAFE_1234, "R2 payload", rd, 32'hCAFE_1234);
    hread(2'd1, rd); chk(rd == 32'h37, "R2 target", rd, 32'h37);
    hread(2'd3, rd); chk(rd == 0, "R2 addr3", rd, 0);
    repeat (3) @(negedge clk);
    chk(pkt_cnt == 0, "R2 read side effect", pkt_cnt, 0);

    // R3 R4 R5: every low code, both broadcast settings
    for (int c = 0; c < 16; c++) begin
      base = pkt_cnt;
      hwrite(2'd0, $urandom);
      hwrite(2'd1, 32'(8'h10 + c));
      hwrite(2'd2, 32'({4'h6, 4'(c)}));
      wait_idle();
      repeat (2) @(negedge clk);
      hread(2'd2, rd);
      chk(rd == 32'({4'h6, 4'(c)}), "R2 cmd readback", rd, 32'({4'h6, 4'(c)}));
      chk(pkt_cnt == base + (is_rsv(3'(c)) ? 0 : 1), is_rsv(3'(c)) ? "R5 no packet" : "R3 one packet",
          pkt_cnt - base, is_rsv(3'(c)) ? 0 : 1);
    end
    chk(own_data_flag == 1'b1, "R5 sticky", own_data_flag, 1);

    // R7 R8: held packet, ignored second command, payload rewrite
    @(negedge clk); pkt_ready = 1'b0;
    hwrite(2'd0, 32'hAAAA_0001);
    hwrite(2'd2, 32'h01);
    hwrite(2'd2, 32'h83);
    hwrite(2'd0, 32'hBBBB_0002);
    hread(2'd2, rd); chk(rd == 32'h01, "R8 cmd ignored", rd, 32'h01);
    chk(pkt_valid && pkt_data == 32'hAAAA_0001, "R7 held data", pkt_data, 32'hAAAA_0001);
    base = pkt_cnt;
    @(negedge clk); pkt_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(pkt_cnt == base + 1, "R8 single packet", pkt_cnt - base, 1);

    // R6 R9 R10: ordering behind earlier writes, full queue, later writes
    @(negedge clk); dw_out_ready = 1'b0;
    dpush(64'hA); dpush(64'hB);
    hwrite(2'd2, 32'h02);
    dpush(64'hC); dpush(64'hD);
    chk(dw_in_ready == 1'b0, "R9 full", dw_in_ready, 0);
    repeat (4) @(negedge clk);
    chk(pkt_valid == 1'b0, "R6 waits", pkt_valid, 0);
    base = pkt_cnt;
    @(negedge clk); dw_out_ready = 1'b1;
    @(negedge clk);
    @(negedge clk); dw_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(pkt_cnt == base + 1 && dw_out_valid, "R10 not delayed", pkt_cnt - base, 1);
    @(negedge clk); dw_out_ready = 1'b1;
    wait_idle();

    // coincidence: command, push and pop in one cycle
    @(negedge clk); dw_out_ready = 1'b0;
    dpush(64'h11); dpush(64'h12);
    @(negedge clk);
    dw_out_ready = 1'b1; dw_in_valid = 1'b1; dw_in_data = 64'h13;
    host_wr = 1'b1; host_addr = 2'd2; host_wdata = 32'h07;
    @(negedge clk);
    dw_in_valid = 1'b0; host_wr = 1'b0; dw_out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(pkt_valid == 1'b0, "R6 same-cycle wait", pkt_valid, 0);
    @(negedge clk); dw_out_ready = 1'b1;
    wait_idle();

    // random phase
    for (int i = 0; i < 4000; i++) rnd_cycle();
    @(negedge clk);
    host_wr = 1'b0; dw_in_valid = 1'b0; dw_out_ready = 1'b1; pkt_ready = 1'b1;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(!cmd_busy && dq.size() == 0, "R9 drained", dq.size(), 0);

    mon_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule